// File: doc/BRIEF.md
# Cache Line Refill Sequencer

This block runs the refill of a single cache line once a lookup has missed. It takes the line address and the offset of the word the processor asked for. It then fetches every word of that line from the next memory level, one request at a time, and collects the words in a local line buffer. When the whole line is present, the buffer is offered to the data array.

The word the processor is waiting for is not held back until the fill ends. It is passed to the processor in the same cycle it comes back from memory. A mode input sets the fetch order. In critical-word-first order the burst begins at the missed word and wraps around the line. In early-restart order the burst runs upward from word 0, and the missed word is forwarded whenever its turn comes.

Top module: `refill_seq`

## Requirements
- R1: While reset is asserted and after its release, `busy`, `mem_req`, `cpu_valid` and `fill_done` are low.
- R2: A miss presented while the block is idle is taken at the clock edge. From the next cycle `busy` and `mem_req` are high, and `mem_addr` equals `{miss_line, word offset}` with the line address in the upper LINE_W bits.
- R3: With `cwf_mode` = 1, the word offsets requested are the missed offset first, then each following offset plus one modulo WORDS (for example 5,6,7,0,1,2,3,4 when WORDS = 8).
- R4: With `cwf_mode` = 0, the word offsets requested are 0,1,...,WORDS-1 in ascending order, whatever the missed offset.
- R5: `cpu_valid` is high in exactly the cycle in which `mem_valid` returns the missed word, and `cpu_data` then equals `mem_rdata`. In every other cycle it is low.
- R6: `cpu_valid` is high in exactly one cycle per refill, including when the missed word is the last word fetched.
- R7: A word is taken only in a cycle with `mem_valid` high. While `mem_valid` is low, `mem_addr` keeps the pending word's address, for any number of wait cycles.
- R8: `fill_done` is high for exactly one cycle, the cycle after the last word is taken. In that cycle `fill_line` equals the missed line and `fill_data[i*WORD_W +: WORD_W]` holds the word returned for offset i.
- R9: `busy` stays high from the cycle after the miss is taken through the `fill_done` cycle, and is low in the cycle after. A miss presented while `busy` is high, including in the `fill_done` cycle, is ignored: it starts no requests and does not change the line being filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | Miss request strobe |
| miss_line | input | LINE_W | Line address of the miss |
| miss_offset | input | OFS_W | Word offset of the missed word within the line |
| cwf_mode | input | 1 | 1: wrapped critical-word-first order, 0: ascending early-restart order |
| busy | output | 1 | A refill is in progress |
| mem_req | output | 1 | A word request is pending towards memory |
| mem_addr | output | LINE_W+OFS_W | Word address of the pending request, {line, offset} |
| mem_valid | input | 1 | Memory returns the pending word this cycle |
| mem_rdata | input | WORD_W | Returned word |
| cpu_valid | output | 1 | Missed word is on cpu_data this cycle |
| cpu_data | output | WORD_W | Missed word for the processor |
| fill_done | output | 1 | One-cycle pulse: complete line on fill_data |
| fill_line | output | LINE_W | Line address of the completed fill |
| fill_data | output | WORDS*WORD_W | Complete line, word i in bits [i*WORD_W +: WORD_W] |

## Verification
The processor-side word is due in the same cycle as its `mem_valid`, so the bench drives each response on the falling edge and samples `cpu_valid` and `cpu_data` a moment later, before the next rising edge. `busy`, `mem_req` and the first `mem_addr` are due one edge after the accepted miss. The address for each later word is due one edge after the previous word's `mem_valid`. `fill_done` is due one edge after the last word. The bench reads each of these at the falling edge that follows the edge it expects to update it, and it counts wait cycles itself so that it knows which response carries which offset.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic [1:0] {
    RF_IDLE  = 2'd0,
    RF_FETCH = 2'd1,
    RF_DONE  = 2'd2
  } refill_state_e;

  // Offset of the word fetched at position 'step' of the burst.
  function automatic int unsigned burst_offset(int unsigned step,
                                               int unsigned start,
                                               logic        wrap,
                                               int unsigned words);
    if (wrap) return (start + step) % words;
    return step;
  endfunction

endpackage

// File: rtl/refill_order_gen.sv
module refill_order_gen
  import refill_pkg::*;
#(
  parameter int WORDS = 8,
  localparam int OFS_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             advance,
  input  logic [OFS_W-1:0] start_ofs,
  input  logic             wrap_mode,
  output logic [OFS_W-1:0] cur_ofs,
  output logic             last_word
);

  logic [OFS_W-1:0] step_q;
  logic [OFS_W-1:0] start_q;
  logic             wrap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= '0;
      start_q <= '0;
      wrap_q  <= 1'b0;
    end else if (start) begin
      step_q  <= '0;
      start_q <= start_ofs;
      wrap_q  <= wrap_mode;
    end else if (advance) begin
      step_q  <= step_q + 1'b1;
    end
  end

  always_comb begin
    cur_ofs   = OFS_W'(burst_offset(int'(step_q), int'(start_q), wrap_q, WORDS));
    last_word = (step_q == OFS_W'(WORDS - 1));
  end

  // R7: position moves only when a word is taken
  assert_step_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !advance) |=> $stable(cur_ofs));

  // R3: consecutive wrapped offsets differ by one
  assert_wrap_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && advance && !last_word && wrap_q) |=> (cur_ofs == $past(cur_ofs) + 1'b1));

endmodule

// File: rtl/refill_line_buf.sv
module refill_line_buf #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  localparam int OFS_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [OFS_W-1:0]        wofs,
  input  logic [WORD_W-1:0]       wdata,
  output logic [WORDS*WORD_W-1:0] line_o
);

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            word_q <= '0;
      else if (we && wofs == OFS_W'(g))      word_q <= wdata;
    end
    assign line_o[g*WORD_W +: WORD_W] = word_q;
  end

  // R8: a taken word lands in its own slot of the line
  assert_slot_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (line_o[$past(wofs)*WORD_W +: WORD_W] == $past(wdata)));

endmodule

// File: rtl/refill_fwd.sv
module refill_fwd #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  localparam int OFS_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              beat,
  input  logic [OFS_W-1:0]  cur_ofs,
  input  logic [OFS_W-1:0]  miss_ofs,
  input  logic [WORD_W-1:0] rdata,
  output logic              cpu_valid,
  output logic [WORD_W-1:0] cpu_data,
  output logic              fwd_seen
);

  logic hit_now;

  always_comb begin
    hit_now   = beat && (cur_ofs == miss_ofs);
    cpu_valid = hit_now;
    cpu_data  = rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fwd_seen <= 1'b0;
    else if (start)     fwd_seen <= 1'b0;
    else if (hit_now)   fwd_seen <= 1'b1;
  end

  // R6: the missed word is handed over only once per refill
  assert_single_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |-> !fwd_seen);

  // R5: forwarding needs a returning word
  assert_fwd_needs_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |-> beat);

endmodule

// File: rtl/refill_seq.sv
module refill_seq
  import refill_pkg::*;
#(
  parameter int LINE_W = 24,
  parameter int WORD_W = 32,
  parameter int WORDS  = 8,
  localparam int OFS_W = $clog2(WORDS),
  localparam int ADDR_W = LINE_W + OFS_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    miss_valid,
  input  logic [LINE_W-1:0]       miss_line,
  input  logic [OFS_W-1:0]        miss_offset,
  input  logic                    cwf_mode,
  output logic                    busy,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic                    mem_valid,
  input  logic [WORD_W-1:0]       mem_rdata,
  output logic                    cpu_valid,
  output logic [WORD_W-1:0]       cpu_data,
  output logic                    fill_done,
  output logic [LINE_W-1:0]       fill_line,
  output logic [WORDS*WORD_W-1:0] fill_data
);

  refill_state_e    state_q, state_d;
  logic [LINE_W-1:0] line_q;
  logic [OFS_W-1:0]  miss_ofs_q;

  // named internal events
  logic             accept;
  logic             beat;
  logic [OFS_W-1:0] cur_ofs;
  logic             last_word;
  logic             fwd_seen;

  always_comb begin
    accept = miss_valid && (state_q == RF_IDLE);
    beat   = (state_q == RF_FETCH) && mem_valid;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RF_IDLE:  if (accept)             state_d = RF_FETCH;
      RF_FETCH: if (beat && last_word)  state_d = RF_DONE;
      RF_DONE:                          state_d = RF_IDLE;
      default:                          state_d = RF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RF_IDLE;
      line_q     <= '0;
      miss_ofs_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        line_q     <= miss_line;
        miss_ofs_q <= miss_offset;
      end
    end
  end

  refill_order_gen #(.WORDS(WORDS)) u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .advance   (beat),
    .start_ofs (miss_offset),
    .wrap_mode (cwf_mode),
    .cur_ofs   (cur_ofs),
    .last_word (last_word)
  );

  refill_line_buf #(.WORDS(WORDS), .WORD_W(WORD_W)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (beat),
    .wofs   (cur_ofs),
    .wdata  (mem_rdata),
    .line_o (fill_data)
  );

  refill_fwd #(.WORDS(WORDS), .WORD_W(WORD_W)) u_fwd (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .beat      (beat),
    .cur_ofs   (cur_ofs),
    .miss_ofs  (miss_ofs_q),
    .rdata     (mem_rdata),
    .cpu_valid (cpu_valid),
    .cpu_data  (cpu_data),
    .fwd_seen  (fwd_seen)
  );

  always_comb begin
    busy      = (state_q != RF_IDLE);
    mem_req   = (state_q == RF_FETCH);
    mem_addr  = {line_q, cur_ofs};
    fill_done = (state_q == RF_DONE);
    fill_line = line_q;
  end

  // R3 R4: first requested offset follows the mode
  assert_first_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mem_addr[OFS_W-1:0] == ($past(cwf_mode) ? $past(miss_offset) : '0)));

  // R9: busy holds until the completion pulse
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fill_done) |=> busy);

  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !fill_done);

  // R6: a line never completes without its missed word having been forwarded
  assert_done_after_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> fwd_seen);

  // R9: line address fixed while requests are pending
  assert_line_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !accept) |=> (mem_addr[ADDR_W-1:OFS_W] == $past(mem_addr[ADDR_W-1:OFS_W])));

endmodule

// File: tb/tb_refill_seq.sv
module tb_refill_seq;

  localparam int CLK_PERIOD = 10;
  localparam int LINE_W = 24;
  localparam int WORD_W = 32;
  localparam int WORDS  = 8;
  localparam int OFS_W  = 3;
  localparam int ADDR_W = LINE_W + OFS_W;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    miss_valid = 1'b0;
  logic [LINE_W-1:0]       miss_line = '0;
  logic [OFS_W-1:0]        miss_offset = '0;
  logic                    cwf_mode = 1'b0;
  logic                    busy, mem_req;
  logic [ADDR_W-1:0]       mem_addr;
  logic                    mem_valid = 1'b0;
  logic [WORD_W-1:0]       mem_rdata = '0;
  logic                    cpu_valid;
  logic [WORD_W-1:0]       cpu_data;
  logic                    fill_done;
  logic [LINE_W-1:0]       fill_line;
  logic [WORDS*WORD_W-1:0] fill_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refill_seq #(.LINE_W(LINE_W), .WORD_W(WORD_W), .WORDS(WORDS)) dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_line(miss_line),
    .miss_offset(miss_offset), .cwf_mode(cwf_mode), .busy(busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .cpu_valid(cpu_valid), .cpu_data(cpu_data), .fill_done(fill_done),
    .fill_line(fill_line), .fill_data(fill_data)
  );

  typedef struct packed {
    logic [LINE_W-1:0] line;
    logic [OFS_W-1:0]  ofs;
    logic              cwf;
    logic [3:0]        waits;
    logic              inject;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{24'h12_3456, 3'd5, 1'b1, 4'd0, 1'b0},
    '{24'hAB_CDEF, 3'd7, 1'b1, 4'd2, 1'b1},
    '{24'h00_0001, 3'd0, 1'b1, 4'd1, 1'b0},
    '{24'h55_AA55, 3'd3, 1'b0, 4'd0, 1'b1},
    '{24'hFF_FFFF, 3'd7, 1'b0, 4'd3, 1'b0},
    '{24'h0F_0F0F, 3'd0, 1'b0, 4'd0, 1'b0},
    '{24'h31_4159, 3'd2, 1'b1, 4'd5, 1'b1}
  };

  function automatic logic [WORD_W-1:0] mem_word(logic [ADDR_W-1:0] a);
    return {5'h16, a};
  endfunction

  function automatic int exp_ofs(int k, int start, logic cwf);
    int r;
    if (!cwf) return k;
    r = start + k;
    if (r >= WORDS) r = r - WORDS;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_refill(input vec_t v);
    int k = 0;
    int wc = 0;
    int cpuc = 0;
    int guard = 0;
    bit done = 0;
    logic [ADDR_W-1:0] ea;
    @(negedge clk);
    miss_valid  = 1'b1;
    miss_line   = v.line;
    miss_offset = v.ofs;
    cwf_mode    = v.cwf;
    @(negedge clk);
    miss_valid  = 1'b0;
    miss_line   = ~v.line;
    miss_offset = v.ofs + 3'd1;
    cwf_mode    = ~v.cwf;
    check(busy && mem_req, "R2", "busy/req after miss", {busy, mem_req}, 2'b11);
    while (!done && guard < 400) begin
      guard++;
      if (fill_done) begin
        mem_valid = 1'b0;
        check(k == WORDS, "R8", "words before done", k, WORDS);
        check(cpuc == 1, "R6", "cpu_valid count", cpuc, 1);
        check(fill_line == v.line, "R8", "fill_line", fill_line, v.line);
        for (int i = 0; i < WORDS; i++) begin
          ea = {v.line, OFS_W'(i)};
          check(fill_data[i*WORD_W +: WORD_W] == mem_word(ea), "R8", "fill word",
                fill_data[i*WORD_W +: WORD_W], mem_word(ea));
        end
        check(busy, "R9", "busy in done cycle", busy, 1);
        if (v.inject) begin
          miss_valid  = 1'b1;
          miss_line   = v.line ^ 24'h1;
          miss_offset = 3'd0;
        end
        done = 1;
      end else begin
        ea = {v.line, OFS_W'(exp_ofs(k, int'(v.ofs), v.cwf))};
        check(mem_req, "R7", "mem_req during fetch", mem_req, 1);
        check(mem_addr == ea, v.cwf ? "R3" : "R4", "mem_addr", mem_addr, ea);
        if (v.inject && k == 2 && wc == 0) begin
          miss_valid  = 1'b1;
          miss_line   = v.line ^ 24'h80;
          miss_offset = v.ofs + 3'd2;
        end else begin
          miss_valid  = 1'b0;
        end
        if (wc == int'(v.waits)) begin
          mem_valid = 1'b1;
          mem_rdata = mem_word(mem_addr);
          wc = 0;
          #1;
          if (exp_ofs(k, int'(v.ofs), v.cwf) == int'(v.ofs)) begin
            check(cpu_valid, "R5", "cpu_valid on missed word", cpu_valid, 1);
            check(cpu_data == mem_word(ea), "R5", "cpu_data", cpu_data, mem_word(ea));
          end else begin
            check(!cpu_valid, "R5", "cpu_valid on other word", cpu_valid, 0);
          end
          if (cpu_valid) cpuc++;
          k++;
        end else begin
          mem_valid = 1'b0;
          mem_rdata = 32'hDEAD_BEEF;
          wc++;
          #1;
          check(!cpu_valid, "R7", "cpu_valid in wait cycle", cpu_valid, 0);
        end
      end
      @(negedge clk);
    end
    if (!done) check(0, "R8", "fill_done never seen", 0, 1);
    miss_valid = 1'b0;
    mem_valid  = 1'b0;
    #1;
    check(!busy && !mem_req && !fill_done, "R9", "idle after done (miss ignored)",
          {busy, mem_req, fill_done}, 3'b000);
    check(!cpu_valid, "R6", "no late cpu_valid", cpu_valid, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(!busy && !mem_req && !cpu_valid && !fill_done, "R1", "outputs in reset",
          {busy, mem_req, cpu_valid, fill_done}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_req && !cpu_valid && !fill_done, "R1", "outputs after reset",
          {busy, mem_req, cpu_valid, fill_done}, 4'b0);

    for (int n = 0; n < NVEC; n++) run_refill(VECS[n]);

    // R9 corner: misses back to back, second taken only once idle
    run_refill('{24'h77_0000, 3'd6, 1'b1, 4'd0, 1'b0});
    run_refill('{24'h77_0001, 3'd6, 1'b0, 4'd1, 1'b0});

    // R7 corner: mem_valid while idle has no effect
    @(negedge clk);
    mem_valid = 1'b1;
    mem_rdata = 32'h1234_5678;
    #1;
    check(!cpu_valid && !busy, "R7", "stray mem_valid while idle", {cpu_valid, busy}, 2'b00);
    @(negedge clk);
    mem_valid = 1'b0;
    #1;
    check(!busy && !fill_done, "R7", "no state after stray mem_valid", {busy, fill_done}, 2'b00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule